// File: doc/BRIEF.md
# Single-Bit Test, Modify and Scan Unit

This execution unit handles the single-bit instructions of an integer pipeline. In one pass it can copy one chosen bit of a 16-bit or 32-bit operand into the carry flag and then leave that bit alone, force it to 1, force it to 0 or invert it. It can also search the operand for a set bit, either upward from bit 0 or downward from the top bit. The chosen bit's position comes from an immediate byte or from a register value. Either way, the position is folded into the active operand width.

The issuing stage presents a request together with `in_valid`. Exactly one clock later the unit returns the operand value, the flags and the scan index, with `out_valid` high for that one cycle. Each operation updates only the flag it defines. The other flag and the scan index keep their previous values. When a scan finds no set bit, the index output also keeps its last value, so downstream logic never sees a made-up index.

Top module: `bitop_unit`

## Requirements
- R1: With op code 0 (bit test), `out_cf` becomes the selected bit of the operand and `out_result` equals the operand. Op codes 6 and 7 behave the same as op code 0.
- R2: With op code 1 (test-and-set), `out_cf` becomes the old selected bit, and `out_result` is the operand with that bit forced to 1.
- R3: With op code 2 (test-and-reset), `out_cf` becomes the old selected bit, and `out_result` is the operand with that bit forced to 0.
- R4: With op code 3 (test-and-complement), `out_cf` becomes the old selected bit, and `out_result` is the operand with that bit inverted.
- R5: The bit position is counted from bit 0. It is taken from `in_imm` when `in_imm_sel`=1 and from `in_reg` when `in_imm_sel`=0. It is reduced modulo the operand width: the low 5 bits in 32-bit mode, the low 4 bits in 16-bit mode.
- R6: With op code 4 (forward scan) on a non-zero operand, `out_index` becomes the position of the lowest set bit and `out_zf` becomes 0.
- R7: With op code 5 (reverse scan) on a non-zero operand, `out_index` becomes the position of the highest set bit and `out_zf` becomes 0. The search starts at bit 15 in 16-bit mode and at bit 31 in 32-bit mode.
- R8: A scan of an all-zero operand sets `out_zf` to 1 and leaves `out_index` at its previous value.
- R9: The test operations (op codes 0 to 3, 6 and 7) leave `out_zf` unchanged. Scans leave `out_cf` unchanged and return the operand on `out_result`.
- R10: In 16-bit mode (`in_wide`=0), operand bits 31..16 take no part in any operation, and `out_result` bits 31..16 are 0.
- R11: `out_valid` goes high exactly one cycle after each cycle in which `in_valid` is high, and is low otherwise. Without `in_valid`, all result outputs hold their values.
- R12: A synchronous active-high `rst` clears `out_valid`, `out_result`, `out_cf`, `out_zf` and `out_index` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 3 | Operation: 0 test, 1 set, 2 reset, 3 complement, 4 forward scan, 5 reverse scan, 6/7 test |
| in_wide | input | 1 | 1 = 32-bit operand, 0 = 16-bit operand |
| in_imm_sel | input | 1 | 1 = bit position from `in_imm`, 0 = from `in_reg` |
| in_imm | input | 8 | Immediate bit position |
| in_reg | input | DW | Register bit position |
| in_opnd | input | DW | Operand |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_result | output | DW | Modified operand (scans: operand) |
| out_cf | output | 1 | Carry flag: old value of the selected bit |
| out_zf | output | 1 | Zero flag from scans |
| out_index | output | IW | Scan index |

## Verification
The bench uses bit positions at and above the operand width, in immediate and register form. A unit that skipped the modulo reduction, or applied it at the wrong width, would pick a different bit and report a wrong carry. It runs scans on operands whose upper half holds set bits while in 16-bit mode. A unit that ignored the width would return indices above 15, and it would clear the zero flag for an operand that is empty in 16-bit mode. It issues empty scans after a successful scan, and test operations after an empty scan. This exposes a unit that clobbers the held index, or that lets one class of operation overwrite the flag owned by the other class. It also checks that the carry captures the bit's value before it is modified; a unit that sampled the modified operand would report the new value instead.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  typedef enum logic [2:0] {
    BOP_TEST  = 3'd0,
    BOP_SET   = 3'd1,
    BOP_CLR   = 3'd2,
    BOP_FLIP  = 3'd3,
    BOP_SCANF = 3'd4,
    BOP_SCANR = 3'd5,
    BOP_RSV6  = 3'd6,
    BOP_RSV7  = 3'd7
  } bop_e;

  function automatic logic bop_is_scan(input bop_e op);
    return (op == BOP_SCANF) || (op == BOP_SCANR);
  endfunction

endpackage

// File: rtl/bitop_offset.sv
module bitop_offset #(
  parameter int DW = 32,
  localparam int IW = $clog2(DW),
  localparam int HW = DW / 2
) (
  input  logic          wide,
  input  logic          imm_sel,
  input  logic [7:0]    imm,
  input  logic [DW-1:0] regv,
  output logic [IW-1:0] pos
);

  logic [DW-1:0] raw;

  always_comb begin
    raw = imm_sel ? {{(DW-8){1'b0}}, imm} : regv;
    if (wide) pos = IW'(raw % DW);
    else      pos = IW'(raw % HW);
  end

endmodule

// File: rtl/bitop_modify.sv
module bitop_modify
  import bitop_pkg::*;
#(
  parameter int DW = 32,
  localparam int IW = $clog2(DW)
) (
  input  bop_e          op,
  input  logic [DW-1:0] opnd,
  input  logic [IW-1:0] pos,
  output logic [DW-1:0] res,
  output logic          old_bit
);

  logic [DW-1:0] hot;

  for (genvar g = 0; g < DW; g++) begin : g_hot
    assign hot[g] = (pos == IW'(g));
  end

  assign old_bit = |(opnd & hot);

  always_comb begin
    unique case (op)
      BOP_SET:  res = opnd | hot;
      BOP_CLR:  res = opnd & ~hot;
      BOP_FLIP: res = opnd ^ hot;
      default:  res = opnd;
    endcase
  end

endmodule

// File: rtl/bitop_scan.sv
module bitop_scan #(
  parameter int DW      = 32,
  parameter bit REVERSE = 1'b0,
  localparam int IW = $clog2(DW)
) (
  input  logic [DW-1:0] vec,
  output logic [IW-1:0] idx,
  output logic          found
);

  assign found = |vec;

  if (REVERSE) begin : g_rev
    always_comb begin
      idx = '0;
      for (int i = 0; i < DW; i++)
        if (vec[i]) idx = IW'(i);
    end
  end else begin : g_fwd
    always_comb begin
      idx = '0;
      for (int i = DW - 1; i >= 0; i--)
        if (vec[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int DW = 32,
  localparam int IW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [2:0]    in_op,
  input  logic          in_wide,
  input  logic          in_imm_sel,
  input  logic [7:0]    in_imm,
  input  logic [DW-1:0] in_reg,
  input  logic [DW-1:0] in_opnd,
  output logic          out_valid,
  output logic [DW-1:0] out_result,
  output logic          out_cf,
  output logic          out_zf,
  output logic [IW-1:0] out_index
);

  localparam int HW = DW / 2;

  bop_e          op;
  logic [DW-1:0] opnd_m;
  logic [IW-1:0] pos;
  logic [DW-1:0] mod_res;
  logic          old_bit;
  logic [IW-1:0] idx_f, idx_r;
  logic          found_f, found_r;

  assign op = bop_e'(in_op);

  for (genvar g = 0; g < DW; g++) begin : g_mask
    if (g < HW) begin : g_lo
      assign opnd_m[g] = in_opnd[g];
    end else begin : g_hi
      assign opnd_m[g] = in_opnd[g] & in_wide;
    end
  end

  bitop_offset #(.DW(DW)) u_ofs (
    .wide(in_wide), .imm_sel(in_imm_sel), .imm(in_imm), .regv(in_reg), .pos(pos)
  );

  bitop_modify #(.DW(DW)) u_mod (
    .op(op), .opnd(opnd_m), .pos(pos), .res(mod_res), .old_bit(old_bit)
  );

  bitop_scan #(.DW(DW), .REVERSE(1'b0)) u_scf (
    .vec(opnd_m), .idx(idx_f), .found(found_f)
  );

  bitop_scan #(.DW(DW), .REVERSE(1'b1)) u_scr (
    .vec(opnd_m), .idx(idx_r), .found(found_r)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_cf     <= 1'b0;
      out_zf     <= 1'b0;
      out_index  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        if (bop_is_scan(op)) begin
          out_result <= opnd_m;
          if (op == BOP_SCANR) begin
            out_zf <= ~found_r;
            if (found_r) out_index <= idx_r;
          end else begin
            out_zf <= ~found_f;
            if (found_f) out_index <= idx_f;
          end
        end else begin
          out_result <= mod_res;
          out_cf     <= old_bit;
        end
      end
    end
  end

endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
  parameter int DW = 32,
  localparam int IW = $clog2(DW)
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [2:0]    in_op,
  input logic          in_wide,
  input logic          in_imm_sel,
  input logic [7:0]    in_imm,
  input logic [DW-1:0] in_reg,
  input logic [DW-1:0] in_opnd,
  input logic          out_valid,
  input logic [DW-1:0] out_result,
  input logic          out_cf,
  input logic          out_zf,
  input logic [IW-1:0] out_index
);

  localparam int HW = DW / 2;

  logic [DW-1:0] c_opnd, c_raw;
  logic [IW-1:0] c_pos;
  logic          c_bit, c_scan, c_plain;

  always_comb begin
    c_opnd = in_wide ? in_opnd : {{HW{1'b0}}, in_opnd[HW-1:0]};
    c_raw  = in_imm_sel ? {{(DW-8){1'b0}}, in_imm} : in_reg;
    c_pos  = IW'(c_raw % (in_wide ? DW : HW));
    c_bit  = c_opnd[c_pos];
    c_scan = (in_op == 3'd4) || (in_op == 3'd5);
    c_plain = (in_op == 3'd0);
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R11
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_result) && $stable(out_cf) && $stable(out_zf) && $stable(out_index)); // R11
  AST_CARRY_OLD_BIT: assert property (@(posedge clk) disable iff (rst)
    in_valid && !c_scan |=> out_cf == $past(c_bit)); // R1
  AST_TEST_OPERAND: assert property (@(posedge clk) disable iff (rst)
    in_valid && c_plain |=> out_result == $past(c_opnd)); // R1
  AST_TEST_KEEPS_ZF: assert property (@(posedge clk) disable iff (rst)
    in_valid && !c_scan |=> $stable(out_zf)); // R9
  AST_SCAN_KEEPS_CF: assert property (@(posedge clk) disable iff (rst)
    in_valid && c_scan |=> $stable(out_cf) && out_result == $past(c_opnd)); // R9
  AST_EMPTY_SCAN: assert property (@(posedge clk) disable iff (rst)
    in_valid && c_scan && c_opnd == '0 |=> out_zf && $stable(out_index)); // R8
  AST_FOUND_BIT_SET: assert property (@(posedge clk) disable iff (rst)
    in_valid && c_scan && c_opnd != '0 |=> !out_zf && out_result[out_index]); // R6

endmodule

bind bitop_unit bitop_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_wide(in_wide),
  .in_imm_sel(in_imm_sel), .in_imm(in_imm), .in_reg(in_reg), .in_opnd(in_opnd),
  .out_valid(out_valid), .out_result(out_result), .out_cf(out_cf),
  .out_zf(out_zf), .out_index(out_index)
);

// File: tb/bitop_unit_test.sv
`timescale 1ns/1ps
module bitop_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  in_op = '0;
  logic        in_wide = 1'b0;
  logic        in_imm_sel = 1'b0;
  logic [7:0]  in_imm = '0;
  logic [31:0] in_reg = '0;
  logic [31:0] in_opnd = '0;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_cf, out_zf;
  logic [4:0]  out_index;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  bitop_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_wide(in_wide),
    .in_imm_sel(in_imm_sel), .in_imm(in_imm), .in_reg(in_reg), .in_opnd(in_opnd),
    .out_valid(out_valid), .out_result(out_result), .out_cf(out_cf),
    .out_zf(out_zf), .out_index(out_index)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic        wide;
    logic        isel;
    logic [7:0]  imm;
    logic [31:0] rg;
    logic [31:0] opnd;
    logic [31:0] e_res;
    logic        e_cf;
    logic        e_zf;
    logic [4:0]  e_idx;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{3'd0, 1'b1, 1'b1, 8'd5,    32'h0,   32'h0000_0020, 32'h0000_0020, 1'b1, 1'b0, 5'd0},  // R1
    '{3'd1, 1'b1, 1'b1, 8'd36,   32'h0,   32'h0000_0020, 32'h0000_0030, 1'b0, 1'b0, 5'd0},  // R2 R5
    '{3'd2, 1'b1, 1'b0, 8'd0,    32'h105, 32'hFFFF_FFFF, 32'hFFFF_FFDF, 1'b1, 1'b0, 5'd0},  // R3 R5
    '{3'd3, 1'b0, 1'b1, 8'h13,   32'h0,   32'hABCD_0008, 32'h0000_0000, 1'b1, 1'b0, 5'd0},  // R4 R10
    '{3'd3, 1'b1, 1'b1, 8'd31,   32'h0,   32'h0000_0001, 32'h8000_0001, 1'b0, 1'b0, 5'd0},  // R4
    '{3'd4, 1'b1, 1'b1, 8'd0,    32'h0,   32'h0001_0100, 32'h0001_0100, 1'b0, 1'b0, 5'd8},  // R6
    '{3'd5, 1'b1, 1'b1, 8'd0,    32'h0,   32'h0001_0100, 32'h0001_0100, 1'b0, 1'b0, 5'd16}, // R7
    '{3'd5, 1'b0, 1'b1, 8'd0,    32'h0,   32'hFFFF_0040, 32'h0000_0040, 1'b0, 1'b0, 5'd6},  // R7 R10
    '{3'd4, 1'b1, 1'b1, 8'd0,    32'h0,   32'h0000_0000, 32'h0000_0000, 1'b0, 1'b1, 5'd6},  // R8
    '{3'd0, 1'b1, 1'b1, 8'd31,   32'h0,   32'h8000_0000, 32'h8000_0000, 1'b1, 1'b1, 5'd6},  // R9
    '{3'd4, 1'b0, 1'b1, 8'd0,    32'h0,   32'hFFFF_0000, 32'h0000_0000, 1'b1, 1'b1, 5'd6},  // R8 R10
    '{3'd5, 1'b0, 1'b1, 8'd0,    32'h0,   32'h0000_8001, 32'h0000_8001, 1'b1, 1'b0, 5'd15}, // R7
    '{3'd4, 1'b1, 1'b1, 8'd0,    32'h0,   32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, 5'd31}, // R6
    '{3'd5, 1'b1, 1'b1, 8'd0,    32'h0,   32'h0000_0001, 32'h0000_0001, 1'b1, 1'b0, 5'd0},  // R7
    '{3'd7, 1'b1, 1'b1, 8'd0,    32'h0,   32'h0000_0002, 32'h0000_0002, 1'b0, 1'b0, 5'd0}   // R1
  };

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic wide, input logic isel,
                       input logic [7:0] imm, input logic [31:0] rg, input logic [31:0] opnd);
    @(negedge clk);
    in_op = op; in_wide = wide; in_imm_sel = isel;
    in_imm = imm; in_reg = rg; in_opnd = opnd; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      default: return "R1";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog: actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12", "valid", 32'(out_valid), 32'd0);
    check("R12", "result", out_result, 32'h0);
    check("R12", "cf", 32'(out_cf), 32'd0);
    check("R12", "zf", 32'(out_zf), 32'd0);
    check("R12", "index", 32'(out_index), 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      vec_t v = TBL[i];
      bit scan = (v.op == 3'd4) || (v.op == 3'd5);
      string stag = v.e_zf ? "R8" : ((v.op == 3'd4) ? "R6" : "R7");
      issue(v.op, v.wide, v.isel, v.imm, v.rg, v.opnd);
      check("R11", "valid", 32'(out_valid), 32'd1);
      check(scan ? "R9" : op_tag(v.op), "result", out_result, v.e_res);
      check(scan ? "R9" : op_tag(v.op), "cf", 32'(out_cf), 32'(v.e_cf));
      check(scan ? stag : "R9", "zf", 32'(out_zf), 32'(v.e_zf));
      check(scan ? stag : "R9", "index", 32'(out_index), 32'(v.e_idx));
    end

    // R5 R10: position 17 folds to 1 in 16-bit mode; bit 17 set, bit 1 clear
    issue(3'd0, 1'b0, 1'b1, 8'd17, 32'h0, 32'h0002_0000);
    check("R5", "cf word fold", 32'(out_cf), 32'd0);
    check("R10", "result upper zero", out_result, 32'h0);
    // R5: register position 0xFFFFFFE3 folds to 3 in 32-bit mode
    issue(3'd0, 1'b1, 1'b0, 8'd0, 32'hFFFF_FFE3, 32'h0000_0008);
    check("R5", "cf reg fold", 32'(out_cf), 32'd1);

    // R11: idle inputs change, outputs hold and valid stays low
    @(negedge clk);
    in_op = 3'd1; in_opnd = 32'hDEAD_BEEF; in_imm = 8'd4; in_wide = 1'b1;
    repeat (3) @(negedge clk);
    check("R11", "idle valid", 32'(out_valid), 32'd0);
    check("R11", "idle result", out_result, 32'h0000_0008);
    check("R11", "idle cf", 32'(out_cf), 32'd1);
    check("R11", "idle index", 32'(out_index), 32'd0);

    // R12: reset after activity; put zf=1 and index=9 first
    issue(3'd4, 1'b1, 1'b1, 8'd0, 32'h0, 32'h0000_0200);
    check("R6", "index before reset", 32'(out_index), 32'd9);
    issue(3'd4, 1'b1, 1'b1, 8'd0, 32'h0, 32'h0);
    check("R8", "zf before reset", 32'(out_zf), 32'd1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R12", "zf after reset", 32'(out_zf), 32'd0);
    check("R12", "index after reset", 32'(out_index), 32'd0);
    check("R12", "cf after reset", 32'(out_cf), 32'd0);
    rst = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule